// File: doc/BRIEF.md
# Supply Fault Reset Combiner

This block drives one active-low reset line from two kinds of cause. The first is a set of digital "supply below threshold" flags from external comparators. They arrive asynchronously and are synchronized inside the block. While any flag is raised the line is held low. Once every flag has cleared, the line stays low for a fixed number of timebase ticks and then goes high. The second cause is a set of single-cycle manual reset requests from upstream pushbutton logic in the same clock domain. Each request produces a low pulse of a fixed number of ticks.

Both hold lengths are counted in ticks of a slow timebase. That timebase reaches the block as a one-cycle `tick` strobe. At a 1 ms tick the defaults of 210 ticks give the usual 140 to 280 ms reset window. A supply fault that returns during the recovery hold clears that hold, and counting resumes only once every supply is good again. The output is low whenever either the supply hold or a manual pulse is active.

Top module: `rstc_combiner`

## Requirements
- R1: A supply flag raised at the input drives `rst_n` low after exactly SYNC_STAGES+1 rising clock edges (3 with the default of two synchronizer stages).
- R2: `rst_n` stays low for as long as any synchronized supply flag is raised, whatever ticks arrive.
- R3: Once every synchronized supply flag is clear, `rst_n` goes high at the clock edge that samples the HOLD_TICKS-th `tick`, counting only ticks sampled while no flag is present.
- R4: A supply flag that returns during the recovery hold, even for one cycle, discards the ticks already counted, so a full HOLD_TICKS ticks are needed after it clears again.
- R5: During and directly after reset `rst_n` is low, and the block treats reset as a supply recovery: with all flags clear it releases after HOLD_TICKS ticks.
- R6: A request on any bit of `man_req` drives `rst_n` low at the next clock edge and holds it low until the edge that samples the PULSE_TICKS-th following tick.
- R7: A new manual request during an active manual pulse restarts that pulse at full length.
- R8: `rst_n` is high only when neither the supply hold nor a manual pulse is active. Whichever finishes first does not release the line.
- R9: When a manual request and a `tick` occur in the same cycle, that tick is not counted toward the new pulse.
- R10: Each of the NUM_SUP supply flags on its own causes the assertion and hold of R1 to R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe of the slow timebase |
| sup_low | input | NUM_SUP | Per-supply below-threshold flags, asynchronous, 1 = fault |
| man_req | input | NUM_MAN | Single-cycle manual reset requests, synchronous |
| rst_n | output | 1 | Combined reset, active low |

## Verification
A supply flag reaches the output after three rising edges: two synchronizer stages and the hold register. A manual request reaches it after one edge. A release lands on the very edge that samples the last counted tick. The bench drives every input just after a falling edge and samples `rst_n` at the following falling edge. For a release, it checks the line once after the tick that should still leave it low and once after the tick that should release it. Before counting recovery ticks it idles three cycles, so that the clear flag has passed the synchronizer.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    // Widest tick count any hold timer in this block may be asked for.
    localparam int TMR_W = 16;

    // State of one tick-counting hold timer.
    typedef struct packed {
        logic             active;
        logic [TMR_W-1:0] cnt;
    } tmr_t;

    // True when a requested length fits the shared counter width.
    function automatic bit len_fits(input int len);
        return (len >= 1) && (len <= (1 << TMR_W));
    endfunction

endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= {WIDTH{RST_VAL}};
                    else     stage_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= {WIDTH{RST_VAL}};
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/rstc_timer.sv
module rstc_timer
    import rstc_pkg::*;
#(
    parameter int LEN        = 210,
    parameter bit ACTIVE_RST = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    output logic             active,
    output logic [TMR_W-1:0] count
);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(LEN - 1);

    tmr_t st_q, st_d;

    initial begin
        if (!len_fits(LEN)) $error("rstc_timer: LEN out of range");
    end

    always_comb begin
        st_d = st_q;
        if (load) begin
            // A load holds the timer at the start; it outranks a same-cycle tick.
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active && tick) begin
            if (st_q.cnt == LAST) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.active <= ACTIVE_RST;
            st_q.cnt    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.active;
    assign count  = st_q.cnt;
endmodule

// File: rtl/rstc_combiner.sv
module rstc_combiner
    import rstc_pkg::*;
#(
    parameter int NUM_SUP     = 2,
    parameter int NUM_MAN     = 2,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_TICKS  = 210,
    parameter int PULSE_TICKS = 210
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic [NUM_SUP-1:0] sup_low,
    input  logic [NUM_MAN-1:0] man_req,
    output logic               rst_n
);
    logic [NUM_SUP-1:0] sup_low_s;
    logic               fault_any;
    logic               man_any;
    logic               sup_active;
    logic               man_active;
    logic [TMR_W-1:0]   sup_cnt;
    logic [TMR_W-1:0]   man_cnt;

    // Flags count as faults while the synchronizer fills after reset.
    rstc_sync #(
        .WIDTH  (NUM_SUP),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (sup_low),
        .dout(sup_low_s)
    );

    assign fault_any = |sup_low_s;
    assign man_any   = |man_req;

    // Supply hold: held at the start while any fault is present (R2, R4).
    rstc_timer #(
        .LEN       (HOLD_TICKS),
        .ACTIVE_RST(1'b1)
    ) u_sup_hold (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .load  (fault_any),
        .active(sup_active),
        .count (sup_cnt)
    );

    // Manual pulse: each request (re)starts a full-length pulse (R6, R7).
    rstc_timer #(
        .LEN       (PULSE_TICKS),
        .ACTIVE_RST(1'b0)
    ) u_man_pulse (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .load  (man_any),
        .active(man_active),
        .count (man_cnt)
    );

    assign rst_n = ~(sup_active | man_active);
endmodule

// File: rtl/rstc_combiner_chk.sv
module rstc_combiner_chk
    import rstc_pkg::*;
#(
    parameter int NUM_MAN    = 2,
    parameter int HOLD_TICKS = 210
) (
    input logic               clk,
    input logic               rst,
    input logic               tick,
    input logic [NUM_MAN-1:0] man_req,
    input logic               rst_n,
    input logic               fault_any,
    input logic [TMR_W-1:0]   sup_cnt
);
    // R1/R2: a synchronized fault keeps the line low on the next cycle.
    p_fault_low_r1: assert property (@(posedge clk) disable iff (rst)
        fault_any |=> !rst_n);

    // R3: the line rises only on a tick edge with no fault present.
    p_release_tick_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_n) |-> ($past(tick) && !$past(fault_any)));

    // R4: the hold count never passes its length.
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
        sup_cnt < TMR_W'(HOLD_TICKS));

    // R6: any manual request drives the line low at the next edge.
    p_manual_low_r6: assert property (@(posedge clk) disable iff (rst)
        (|man_req) |=> !rst_n);

    // R8: the line only falls for a fault or a request.
    p_fall_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_n) |-> ($past(fault_any) || $past(|man_req)));
endmodule

bind rstc_combiner rstc_combiner_chk #(
    .NUM_MAN   (NUM_MAN),
    .HOLD_TICKS(HOLD_TICKS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .man_req  (man_req),
    .rst_n    (rst_n),
    .fault_any(fault_any),
    .sup_cnt  (sup_cnt)
);

// File: tb/sim_rstc_combiner.sv
`timescale 1ns/1ps
module sim_rstc_combiner;
    localparam int NS = 2, NM = 2, HOLD = 4, PULSE = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic [NS-1:0] sup_low = '0;
    logic [NM-1:0] man_req = '0;
    logic          rst_n;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rstc_combiner #(
        .NUM_SUP(NS), .NUM_MAN(NM), .SYNC_STAGES(2),
        .HOLD_TICKS(HOLD), .PULSE_TICKS(PULSE)
    ) u0 (
        .clk(clk), .rst(rst), .tick(tick),
        .sup_low(sup_low), .man_req(man_req), .rst_n(rst_n)
    );

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string tag);
        checks++;
        if (rst_n !== exp) begin
            fails++;
            $display("FAIL %s: rst_n=%b expected %b at %0t", tag, rst_n, exp, $time);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; cyc(); tick = 1'b0; cyc();
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; cyc(3);
        chk(1'b0, "R5 low in reset");
        rst = 1'b0; cyc(4);
        chk(1'b0, "R5 low after reset");
        ticks(HOLD - 1);
        chk(1'b0, "R5 still held");
        ticks(1);
        chk(1'b1, "R5 release after hold");
    endtask

    task automatic t_fault(input int idx);
        sup_low[idx] = 1'b1;
        cyc(); chk(1'b1, "R1 edge 1");
        cyc(); chk(1'b1, "R1 edge 2");
        cyc(); chk(1'b0, "R1/R10 edge 3 low");
        ticks(HOLD + 2);
        chk(1'b0, "R2 low while fault");
        sup_low[idx] = 1'b0; cyc(3);
        ticks(HOLD - 1);
        chk(1'b0, "R3 before last tick");
        ticks(1);
        chk(1'b1, "R3 release on last tick");
    endtask

    task automatic t_refault;
        sup_low[1] = 1'b1; cyc(4);
        sup_low[1] = 1'b0; cyc(3);
        ticks(2);
        sup_low[1] = 1'b1; cyc();
        sup_low[1] = 1'b0; cyc(5);
        ticks(HOLD - 1);
        chk(1'b0, "R4 count discarded");
        ticks(1);
        chk(1'b1, "R4 release after full hold");
    endtask

    task automatic t_manual;
        man_req[1] = 1'b1; cyc(); man_req = '0;
        chk(1'b0, "R6 low next edge");
        ticks(PULSE - 1);
        chk(1'b0, "R6 pulse held");
        ticks(1);
        chk(1'b1, "R6 pulse end");
    endtask

    task automatic t_retrigger;
        man_req[0] = 1'b1; cyc(); man_req = '0;
        ticks(PULSE - 1);
        man_req[1] = 1'b1; cyc(); man_req = '0;
        ticks(PULSE - 1);
        chk(1'b0, "R7 restarted");
        ticks(1);
        chk(1'b1, "R7 end of restarted pulse");
    endtask

    task automatic t_same_cycle;
        man_req[0] = 1'b1; tick = 1'b1; cyc();
        man_req = '0; tick = 1'b0; cyc();
        ticks(PULSE - 1);
        chk(1'b0, "R9 tick not counted");
        ticks(1);
        chk(1'b1, "R9 end");
    endtask

    task automatic t_overlap;
        sup_low[0] = 1'b1; cyc(4);
        sup_low[0] = 1'b0; cyc(3);
        ticks(2);
        man_req[0] = 1'b1; cyc(); man_req = '0;
        ticks(HOLD - 2);
        chk(1'b0, "R8 manual outlives hold");
        ticks(PULSE - (HOLD - 2));
        chk(1'b1, "R8 both done");
        man_req[1] = 1'b1; sup_low[1] = 1'b1; cyc(); man_req = '0;
        cyc(3);
        ticks(PULSE + 1);
        chk(1'b0, "R8 fault outlives manual");
        sup_low[1] = 1'b0; cyc(3);
        ticks(HOLD);
        chk(1'b1, "R8 hold done");
    endtask

    initial begin
        cyc(2);
        t_reset();
        t_fault(0);
        t_fault(1);
        t_refault();
        t_manual();
        t_retrigger();
        t_same_cycle();
        t_overlap();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run hung, actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule